// File: doc/BRIEF.md
# Event-driven output set/clear controller

This block owns a bank of timer output pins and changes them in response to single-cycle event pulses from elsewhere in the timer. Each output has a set-select mask and a clear-select mask over the event vector. When a selected event fires, the output goes high (set) or low (clear) on the next clock edge. If set and clear events reach the same output in one cycle, a per-output conflict rule picks the result. The conflict is also logged in a sticky flag, and an enabled flag raises an interrupt.

When a bidirectional counter counts down, a per-output direction field can swap the set and clear roles of events. This keeps a centre-aligned waveform symmetric. Software configures the block through a simple word-addressed write/read port. Through the same port it can read the live output levels or load them directly.

Top module: `ocx_evt_out`

## Requirements
- R1: After reset every output is 0, `irq_o` is 0, and every register reads back as 0.
- R2: Each output n has a set mask at address 2n, with bit e selecting event e. If any selected event fires and no effective clear hits that output, the output is 1 after the next clock edge.
- R3: Each output n has a clear mask at address 2n+1, with bit e selecting event e. If any selected event fires and no effective set hits that output, the output is 0 after the next clock edge.
- R4: An output that receives neither an effective set nor an effective clear, and is not written by software, keeps its level.
- R5: A conflict is a cycle in which both an effective set and an effective clear hit one output. The conflict rule for output n is bits [2n+1:2n] at address 16: 00 keeps the level, 01 sets it, 10 clears it, 11 toggles it.
- R6: A conflict on output n sets bit n of the flag register at address 18. The bit stays set until software writes a 1 to it. A conflict in the same cycle as that write leaves the bit set.
- R7: `irq_o` is high exactly when some bit of the flag register and the same bit of the enable register at address 19 are both 1.
- R8: The direction field for output n is bits [2n+1:2n] at address 17. Code 01 swaps the set and clear roles while `cnt_down_l_i` is high, and code 10 does so while `cnt_down_h_i` is high. Codes 00 and 11 never swap.
- R9: A write to address 20 loads the outputs from the write data bits [7:0]. It overrides any event-driven change in the same cycle.
- R10: A read returns the last written value of each configuration register. It returns the current output levels at address 20 and 0 at unmapped addresses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| evt_i | input | 16 | Event pulses, one bit per event |
| cnt_down_l_i | input | 1 | Low counter is counting down |
| cnt_down_h_i | input | 1 | High counter is counting down |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 5 | Register word address |
| reg_wdata_i | input | 16 | Register write data |
| reg_rdata_o | output | 16 | Register read data, combinational from address |
| out_o | output | 8 | Output levels |
| irq_o | output | 1 | Conflict interrupt |

## Verification
Assertions check on every cycle that a lone set raises its output and a lone clear drops it. They also check that an untouched output holds its level, that a toggle conflict flips the level, that a software write wins, that conflict flags only rise on a conflict and stay up until a clearing write, and that the interrupt never fires without a flag and an enable. Only the bench scenarios can show the mapping from register addresses and bit positions to behaviour. The same holds for the direction codes against each counter's down signal, the hold, set and clear conflict codes, and the flag clear racing a new conflict. A random phase compares outputs, interrupt and readback against a model on every cycle.

// File: rtl/ocx_pkg.sv
package ocx_pkg;
  typedef enum logic [1:0] {
    RES_HOLD   = 2'b00,
    RES_SET    = 2'b01,
    RES_CLR    = 2'b10,
    RES_TOGGLE = 2'b11
  } res_e;

  typedef enum logic [1:0] {
    DIR_NONE   = 2'b00,
    DIR_SWAP_L = 2'b01,
    DIR_SWAP_H = 2'b10,
    DIR_RSVD   = 2'b11
  } dir_e;
endpackage

// File: rtl/ocx_regs.sv
module ocx_regs #(
  parameter int N_OUT  = 8,
  parameter int N_EVT  = 16,
  parameter int DATA_W = 16,
  parameter int ADDR_W = 5
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic                          we_i,
  input  logic [ADDR_W-1:0]             addr_i,
  input  logic [DATA_W-1:0]             wdata_i,
  input  logic [N_OUT-1:0]              conf_i,
  input  logic [N_OUT-1:0]              out_i,
  output logic [N_OUT-1:0][N_EVT-1:0]   set_mask_o,
  output logic [N_OUT-1:0][N_EVT-1:0]   clr_mask_o,
  output logic [N_OUT-1:0][1:0]         res_o,
  output logic [N_OUT-1:0][1:0]         dir_o,
  output logic [N_OUT-1:0]              flag_o,
  output logic [N_OUT-1:0]              en_o,
  output logic                          sw_we_o,
  output logic [DATA_W-1:0]             rdata_o
);
  localparam int A_RES  = 2 * N_OUT;
  localparam int A_DIR  = A_RES + 1;
  localparam int A_FLAG = A_RES + 2;
  localparam int A_EN   = A_RES + 3;
  localparam int A_OUT  = A_RES + 4;

  logic [N_OUT-1:0][N_EVT-1:0] set_q, clr_q;
  logic [N_OUT-1:0][1:0]       res_q, dir_q;
  logic [N_OUT-1:0]            flag_q, en_q;
  logic                        flag_wr;

  assign flag_wr = we_i && (addr_i == ADDR_W'(A_FLAG));
  assign sw_we_o = we_i && (addr_i == ADDR_W'(A_OUT));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      set_q <= '0;
      clr_q <= '0;
      res_q <= '0;
      dir_q <= '0;
      en_q  <= '0;
    end else if (we_i) begin
      for (int n = 0; n < N_OUT; n++) begin
        if (addr_i == ADDR_W'(2 * n))     set_q[n] <= wdata_i[N_EVT-1:0];
        if (addr_i == ADDR_W'(2 * n + 1)) clr_q[n] <= wdata_i[N_EVT-1:0];
      end
      if (addr_i == ADDR_W'(A_RES)) res_q <= wdata_i[2*N_OUT-1:0];
      if (addr_i == ADDR_W'(A_DIR)) dir_q <= wdata_i[2*N_OUT-1:0];
      if (addr_i == ADDR_W'(A_EN))  en_q  <= wdata_i[N_OUT-1:0];
    end
  end

  // new conflicts win over a same-cycle clearing write
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) flag_q <= '0;
    else         flag_q <= (flag_q & ~(flag_wr ? wdata_i[N_OUT-1:0] : '0)) | conf_i;
  end

  always_comb begin
    rdata_o = '0;
    for (int n = 0; n < N_OUT; n++) begin
      if (addr_i == ADDR_W'(2 * n))     rdata_o[N_EVT-1:0] = set_q[n];
      if (addr_i == ADDR_W'(2 * n + 1)) rdata_o[N_EVT-1:0] = clr_q[n];
    end
    if (addr_i == ADDR_W'(A_RES))  rdata_o[2*N_OUT-1:0] = res_q;
    if (addr_i == ADDR_W'(A_DIR))  rdata_o[2*N_OUT-1:0] = dir_q;
    if (addr_i == ADDR_W'(A_FLAG)) rdata_o[N_OUT-1:0]   = flag_q;
    if (addr_i == ADDR_W'(A_EN))   rdata_o[N_OUT-1:0]   = en_q;
    if (addr_i == ADDR_W'(A_OUT))  rdata_o[N_OUT-1:0]   = out_i;
  end

  assign set_mask_o = set_q;
  assign clr_mask_o = clr_q;
  assign res_o      = res_q;
  assign dir_o      = dir_q;
  assign flag_o     = flag_q;
  assign en_o       = en_q;

  AST_FLAG_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !flag_wr |=> (flag_q & $past(flag_q)) == $past(flag_q)); // R6
  AST_FLAG_ONLY_ON_CONFLICT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (conf_i == '0) |=> (flag_q & ~$past(flag_q)) == '0); // R6
endmodule

// File: rtl/ocx_slice.sv
module ocx_slice
  import ocx_pkg::*;
#(
  parameter int N_EVT = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [N_EVT-1:0] evt_i,
  input  logic [N_EVT-1:0] set_mask_i,
  input  logic [N_EVT-1:0] clr_mask_i,
  input  logic [1:0]       res_i,
  input  logic [1:0]       dir_i,
  input  logic             down_l_i,
  input  logic             down_h_i,
  input  logic             sw_we_i,
  input  logic             sw_val_i,
  output logic             q_o,
  output logic             conf_o
);
  logic set_raw, clr_raw, swap, set_hit, clr_hit;
  logic q_q, q_d;

  assign set_raw = |(set_mask_i & evt_i);
  assign clr_raw = |(clr_mask_i & evt_i);

  always_comb begin
    case (dir_e'(dir_i))
      DIR_SWAP_L: swap = down_l_i;
      DIR_SWAP_H: swap = down_h_i;
      default:    swap = 1'b0;
    endcase
  end

  assign set_hit = swap ? clr_raw : set_raw;
  assign clr_hit = swap ? set_raw : clr_raw;
  assign conf_o  = set_hit & clr_hit;

  always_comb begin
    q_d = q_q;
    if (set_hit && clr_hit) begin
      case (res_e'(res_i))
        RES_SET:    q_d = 1'b1;
        RES_CLR:    q_d = 1'b0;
        RES_TOGGLE: q_d = ~q_q;
        default:    q_d = q_q;
      endcase
    end else if (set_hit) begin
      q_d = 1'b1;
    end else if (clr_hit) begin
      q_d = 1'b0;
    end
    if (sw_we_i) q_d = sw_val_i; // software wins
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) q_q <= 1'b0;
    else         q_q <= q_d;
  end

  assign q_o = q_q;

  AST_SET_HIGH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (set_hit && !clr_hit && !sw_we_i) |=> q_o); // R2
  AST_CLR_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_hit && !set_hit && !sw_we_i) |=> !q_o); // R3
  AST_IDLE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!set_raw && !clr_raw && !sw_we_i) |=> $stable(q_o)); // R4
  AST_TOGGLE_FLIP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (conf_o && res_i == 2'b11 && !sw_we_i) |=> q_o != $past(q_o)); // R5
  AST_SW_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sw_we_i |=> q_o == $past(sw_val_i)); // R9
endmodule

// File: rtl/ocx_evt_out.sv
module ocx_evt_out #(
  parameter int N_OUT  = 8,
  parameter int N_EVT  = 16,
  parameter int DATA_W = 16,
  parameter int ADDR_W = $clog2(2 * N_OUT + 5)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [N_EVT-1:0]  evt_i,
  input  logic              cnt_down_l_i,
  input  logic              cnt_down_h_i,
  input  logic              reg_we_i,
  input  logic [ADDR_W-1:0] reg_addr_i,
  input  logic [DATA_W-1:0] reg_wdata_i,
  output logic [DATA_W-1:0] reg_rdata_o,
  output logic [N_OUT-1:0]  out_o,
  output logic              irq_o
);
  logic [N_OUT-1:0][N_EVT-1:0] set_mask, clr_mask;
  logic [N_OUT-1:0][1:0]       res, dir;
  logic [N_OUT-1:0]            flag, en, conf, q;
  logic                        sw_we;

  ocx_regs #(
    .N_OUT(N_OUT), .N_EVT(N_EVT), .DATA_W(DATA_W), .ADDR_W(ADDR_W)
  ) u_regs (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .we_i       (reg_we_i),
    .addr_i     (reg_addr_i),
    .wdata_i    (reg_wdata_i),
    .conf_i     (conf),
    .out_i      (q),
    .set_mask_o (set_mask),
    .clr_mask_o (clr_mask),
    .res_o      (res),
    .dir_o      (dir),
    .flag_o     (flag),
    .en_o       (en),
    .sw_we_o    (sw_we),
    .rdata_o    (reg_rdata_o)
  );

  for (genvar n = 0; n < N_OUT; n++) begin : g_out
    ocx_slice #(.N_EVT(N_EVT)) u_slice (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .evt_i      (evt_i),
      .set_mask_i (set_mask[n]),
      .clr_mask_i (clr_mask[n]),
      .res_i      (res[n]),
      .dir_i      (dir[n]),
      .down_l_i   (cnt_down_l_i),
      .down_h_i   (cnt_down_h_i),
      .sw_we_i    (sw_we),
      .sw_val_i   (reg_wdata_i[n]),
      .q_o        (q[n]),
      .conf_o     (conf[n])
    );
  end

  assign out_o = q;
  assign irq_o = |(flag & en);

  AST_IRQ_NEEDS_FLAG_EN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> (flag != '0 && en != '0)); // R7
  AST_RESET_CLEAN: assert property (@(posedge clk_i)
    !rst_ni |-> (out_o == '0 && !irq_o)); // R1
endmodule

// File: tb/sim_ocx_evt_out.sv
module sim_ocx_evt_out;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] evt = '0;
  logic        dl = 1'b0, dh = 1'b0;
  logic        we = 1'b0;
  logic [4:0]  addr = '0;
  logic [15:0] wdata = '0;
  logic [15:0] rdata;
  logic [7:0]  out;
  logic        irq;

  int n_chk = 0;
  int n_fail = 0;
  bit run_model_chk = 1'b0;

  logic [15:0] m_set [8];
  logic [15:0] m_clr [8];
  logic [15:0] m_res, m_dir;
  logic [7:0]  m_flag, m_en, m_out;

  always #(CLK_PERIOD / 2) clk = ~clk;

  ocx_evt_out u0 (
    .clk_i        (clk),
    .rst_ni       (rst_n),
    .evt_i        (evt),
    .cnt_down_l_i (dl),
    .cnt_down_h_i (dh),
    .reg_we_i     (we),
    .reg_addr_i   (addr),
    .reg_wdata_i  (wdata),
    .reg_rdata_o  (rdata),
    .out_o        (out),
    .irq_o        (irq)
  );

  task automatic chk(string tag, logic [15:0] act, logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h t=%0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic [15:0] model_rd(logic [4:0] a);
    if (a < 5'd16) return a[0] ? m_clr[a >> 1] : m_set[a >> 1];
    case (a)
      5'd16:   return m_res;
      5'd17:   return m_dir;
      5'd18:   return {8'h0, m_flag};
      5'd19:   return {8'h0, m_en};
      5'd20:   return {8'h0, m_out};
      default: return 16'h0;
    endcase
  endfunction

  task automatic model_step();
    logic [7:0] nout, conf, nflag;
    logic s, c, t, nb, sw;
    logic [1:0] r, d;
    conf = '0;
    for (int n = 0; n < 8; n++) begin
      s = |(m_set[n] & evt);
      c = |(m_clr[n] & evt);
      r = m_res[2*n +: 2];
      d = m_dir[2*n +: 2];
      sw = (d == 2'b01 && dl) || (d == 2'b10 && dh);
      if (sw) begin t = s; s = c; c = t; end
      nb = m_out[n];
      if (s && c) begin
        conf[n] = 1'b1;
        if (r == 2'b01) nb = 1'b1;
        else if (r == 2'b10) nb = 1'b0;
        else if (r == 2'b11) nb = ~nb;
      end else if (s) nb = 1'b1;
      else if (c) nb = 1'b0;
      nout[n] = nb;
    end
    nflag = m_flag | conf;
    if (we) begin
      if (addr < 5'd16) begin
        if (addr[0]) m_clr[addr >> 1] = wdata;
        else         m_set[addr >> 1] = wdata;
      end
      case (addr)
        5'd16: m_res = wdata;
        5'd17: m_dir = wdata;
        5'd18: nflag = (m_flag & ~wdata[7:0]) | conf;
        5'd19: m_en = wdata[7:0];
        5'd20: nout = wdata[7:0];
        default: ;
      endcase
    end
    m_out = nout;
    m_flag = nflag;
  endtask

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int n = 0; n < 8; n++) begin m_set[n] = '0; m_clr[n] = '0; end
      m_res = '0; m_dir = '0; m_flag = '0; m_en = '0; m_out = '0;
    end else begin
      model_step();
    end
  end

  // continuous comparison against the model
  always @(negedge clk) begin
    if (rst_n && run_model_chk) begin
      chk("R2 model out", {8'h0, out}, {8'h0, m_out});
      chk("R7 model irq", {15'h0, irq}, {15'h0, |(m_flag & m_en)});
    end
  end

  task automatic wr(logic [4:0] a, logic [15:0] d);
    we = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    we = 1'b0; wdata = '0;
  endtask

  task automatic pulse(logic [15:0] e);
    evt = e;
    @(negedge clk);
    evt = '0;
  endtask

  task automatic rd(string tag, logic [4:0] a, logic [15:0] exp);
    addr = a;
    #1;
    chk(tag, rdata, exp);
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    run_model_chk = 1'b1;

    // R1 reset state
    chk("R1 out", {8'h0, out}, 16'h0);
    chk("R1 irq", {15'h0, irq}, 16'h0);
    rd("R1 set0", 5'd0, 16'h0);
    rd("R1 res", 5'd16, 16'h0);
    rd("R1 flag", 5'd18, 16'h0);

    // R10 readback
    wr(5'd0, 16'h0001);
    rd("R10 set0", 5'd0, 16'h0001);
    wr(5'd1, 16'h0002);
    rd("R10 clr0", 5'd1, 16'h0002);

    pulse(16'h0001);
    chk("R2 set", {8'h0, out}, 16'h0001);
    pulse(16'h0020);
    chk("R4 hold", {8'h0, out}, 16'h0001);
    pulse(16'h0002);
    chk("R3 clear", {8'h0, out}, 16'h0000);

    // R5 conflict codes
    wr(5'd16, 16'h0003);
    pulse(16'h0003);
    chk("R5 toggle up", {8'h0, out}, 16'h0001);
    pulse(16'h0003);
    chk("R5 toggle down", {8'h0, out}, 16'h0000);
    wr(5'd16, 16'h0001);
    pulse(16'h0003);
    chk("R5 set", {8'h0, out}, 16'h0001);
    wr(5'd16, 16'h0002);
    pulse(16'h0003);
    chk("R5 clear", {8'h0, out}, 16'h0000);
    pulse(16'h0001);
    wr(5'd16, 16'h0000);
    pulse(16'h0003);
    chk("R5 hold", {8'h0, out}, 16'h0001);

    // R6 / R7 flags and interrupt
    rd("R6 flag set", 5'd18, 16'h0001);
    chk("R7 irq masked", {15'h0, irq}, 16'h0);
    wr(5'd19, 16'h0001);
    chk("R7 irq enabled", {15'h0, irq}, 16'h1);
    wr(5'd18, 16'h0001);
    rd("R6 flag w1c", 5'd18, 16'h0000);
    chk("R7 irq cleared", {15'h0, irq}, 16'h0);
    we = 1'b1; addr = 5'd18; wdata = 16'h0001; evt = 16'h0003;
    @(negedge clk);
    we = 1'b0; wdata = '0; evt = '0;
    rd("R6 conflict beats clear", 5'd18, 16'h0001);
    wr(5'd18, 16'h0001);

    // R8 direction swap, out0 currently 1
    wr(5'd17, 16'h0001);
    dl = 1'b1;
    pulse(16'h0001);
    chk("R8 swap L", {8'h0, out}, 16'h0000);
    dl = 1'b0; dh = 1'b1;
    pulse(16'h0001);
    chk("R8 no swap on H with code 01", {8'h0, out}, 16'h0001);
    wr(5'd17, 16'h0002);
    pulse(16'h0001);
    chk("R8 swap H", {8'h0, out}, 16'h0000);
    wr(5'd17, 16'h0003);
    dl = 1'b1;
    pulse(16'h0001);
    chk("R8 code 11 no swap", {8'h0, out}, 16'h0001);
    dl = 1'b0; dh = 1'b0;

    // R9 software write
    wr(5'd20, 16'h00A5);
    chk("R9 load", {8'h0, out}, 16'h00A5);
    rd("R10 out read", 5'd20, 16'h00A5);
    we = 1'b1; addr = 5'd20; wdata = 16'h0000; evt = 16'h0001;
    @(negedge clk);
    we = 1'b0; evt = '0;
    chk("R9 priority", {8'h0, out}, 16'h0000);
    rd("R10 unmapped", 5'd23, 16'h0000);

    // random phase
    for (int n = 0; n < 16; n++) wr(5'(n), 16'($urandom & $urandom));
    wr(5'd16, 16'($urandom));
    wr(5'd17, 16'($urandom));
    wr(5'd19, 16'($urandom));
    for (int i = 0; i < 3000; i++) begin
      evt   = 16'($urandom & $urandom & $urandom);
      dl    = 1'($urandom);
      dh    = 1'($urandom);
      we    = ($urandom % 8) == 0;
      addr  = 5'($urandom % 24);
      wdata = (addr < 5'd16) ? 16'($urandom & $urandom) : 16'($urandom);
      #1;
      chk("R10 random read", rdata, model_rd(addr));
      @(negedge clk);
    end
    we = 1'b0; evt = '0;
    @(negedge clk);
    summary();
  end
endmodule